// File: doc/BRIEF.md
# Card Interface Status and Interrupt Controller

This block holds the status word that a host reads from a memory or storage card interface and turns it into two interrupt lines. The command and data engines report events as one-cycle pulses. Each pulse sets a bit that stays set until the host clears it. A second group of status bits shows the transmit and receive buffer levels. These bits are live inputs: they are never stored and the host cannot clear them.

The host reaches the block through a simple 32-bit register port. It writes with a one-cycle write strobe, and it reads with a one-cycle read strobe whose data comes back one cycle later. The host clears events with a write-one-to-clear register. Each of the two mask registers selects which status bits drive its own level-sensitive interrupt output, so one interrupt can serve, for example, command completion and the other data flow. A read-only window at the top of the register space returns a fixed eight-byte identification sequence, one byte per word.

Top module: `card_stat_irq`

## Requirements
- R1: After reset the stored event bits and both masks are zero, both interrupt outputs are low and the read data output is zero.
- R2: A one-cycle pulse on `evt_set[k]` sets status bit k at the next clock edge, and the bit stays set until cleared. The event bit positions are: 0 command CRC fail, 1 data CRC fail, 2 command timeout, 3 data timeout, 4 transmit underrun, 5 receive overrun, 6 response received, 7 command sent, 8 data end, 10 data block end.
- R3: Bit 9 is reserved. A pulse on `evt_set[9]` is ignored, and status bit 9 always reads 0.
- R4: A read at byte offset 0x34 returns the status word on `reg_rdata` in the cycle after the read strobe. Bits [10:0] hold the stored events. Bits [21:11] are `live_lvl[10:0]`, in the order: 11 command active, 12 transmit active, 13 receive active, 14 transmit half-empty, 15 receive half-full, 16 transmit full, 17 receive full, 18 transmit empty, 19 receive empty, 20 transmit data available, 21 receive data available. Bits [31:22] read 0.
- R5: A write to byte offset 0x38 clears each stored event bit whose `reg_wdata` bit is 1, for bits [10:0] only. Write-data bits 11 and above have no effect.
- R6: When a set pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R7: Mask 0 is at byte offset 0x3C and mask 1 at 0x40. Each mask can be written and read back. It keeps write-data bits [21:0], and bits [31:22] read 0.
- R8: `irq[n]` is high exactly when the status word (stored events and live bits) ANDed with mask n is non-zero. It follows a change of an event, a mask or a live bit with no added register delay.
- R9: Reads at byte offsets 0xFE0, 0xFE4, and so on up to 0xFFC return, in address order, 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with all upper bits 0.
- R10: Reads at unmapped offsets, including the write-only offset 0x38, return 0. Writes to unmapped offsets, to the status offset 0x34, and to the identification window change no state. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd`, held otherwise |
| evt_set | input | 11 | One-cycle event pulses, one per event bit |
| live_lvl | input | 11 | Live buffer-level flags shown in status bits [21:11] |
| irq | output | 2 | Level interrupts, one per mask |

## Verification
The timing of each result sets when the bench samples it. An event pulse or a register write takes effect at the next rising edge. The interrupt lines are decoded combinationally from registers and live inputs, so the bench samples them at the falling edge right after the pulse or write, or after a live input changes. Read data is registered, so each read strobe puts its expected word into a scoreboard queue. A monitor then pops that word and compares it at the falling edge after the edge that captured the strobe, which keeps every comparison exactly one cycle behind its request. The same-cycle set-and-clear case is driven on one edge and read back on the next cycle.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;

    // Word offsets (byte offset >> 2) of the host-visible registers
    localparam int unsigned STAT_WORD  = 32'h0D;   // 0x34
    localparam int unsigned CLR_WORD   = 32'h0E;   // 0x38
    localparam int unsigned MASK_WORD  = 32'h0F;   // 0x3C, next mask at +1
    localparam int unsigned ID_WORD    = 32'h3F8;  // 0xFE0 .. 0xFFC
    localparam int unsigned ID_CNT     = 8;

    // Read path state carried between the two processes
    typedef struct packed {
        logic [31:0] rdata;
    } rd_state_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h81;
            3'd1:    b = 8'h11;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/card_stat_evt.sv
// Sticky event bits: set by pulses, cleared by host, set dominates.
module card_stat_evt #(
    parameter int EVT_W    = 11,
    parameter int RSVD_IDX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] set_i,
    input  logic [EVT_W-1:0] clr_i,
    output logic [EVT_W-1:0] evt_o
);
    localparam logic [EVT_W-1:0] KEEP_MASK = ~(EVT_W'(1) << RSVD_IDX);

    typedef struct packed {
        logic [EVT_W-1:0] evt;
    } evt_state_t;

    evt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = ((st_q.evt & ~clr_i) | set_i) & KEEP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

endmodule

// File: rtl/card_stat_mask.sv
// One mask register and one interrupt line per output.
module card_stat_mask #(
    parameter int STAT_W  = 22,
    parameter int NUM_IRQ = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_IRQ-1:0]               wr_en_i,
    input  logic [STAT_W-1:0]                wdata_i,
    input  logic [STAT_W-1:0]                status_i,
    output logic [NUM_IRQ-1:0][STAT_W-1:0]   mask_o,
    output logic [NUM_IRQ-1:0]               irq_o
);
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        logic [STAT_W-1:0] mask_d, mask_q;

        always_comb begin
            mask_d = mask_q;
            if (wr_en_i[g]) begin
                mask_d = wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else begin
                mask_q <= mask_d;
            end
        end

        assign mask_o[g] = mask_q;
        assign irq_o[g]  = |(status_i & mask_q);
    end

endmodule

// File: rtl/card_stat_id.sv
// Fixed identification bytes, one per word of the window.
module card_stat_id #(
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [7:0]       id_o
);
    always_comb begin
        id_o = card_stat_pkg::id_byte(3'(sel_i));
    end

endmodule

// File: rtl/card_stat_irq.sv
module card_stat_irq #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int EVT_W    = 11,
    parameter int LIVE_W   = 11,
    parameter int NUM_IRQ  = 2,
    parameter int RSVD_IDX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [EVT_W-1:0]    evt_set,
    input  logic [LIVE_W-1:0]   live_lvl,
    output logic [NUM_IRQ-1:0]  irq
);
    import card_stat_pkg::*;

    localparam int STAT_W = EVT_W + LIVE_W;
    localparam int WORD_W = ADDR_W - 2;
    localparam int SEL_W  = $clog2(ID_CNT);

    logic [WORD_W-1:0]               word;
    logic [EVT_W-1:0]                clr_vec;
    logic [EVT_W-1:0]                evt_q;
    logic [STAT_W-1:0]               status;
    logic [NUM_IRQ-1:0]              mask_we;
    logic [NUM_IRQ-1:0][STAT_W-1:0]  mask_v;
    logic [7:0]                      id_val;
    logic                            id_hit;
    rd_state_t                       rd_d, rd_q;

    assign word   = reg_addr[ADDR_W-1:2];
    assign status = {live_lvl, evt_q};
    assign id_hit = (word >> SEL_W) == (WORD_W'(ID_WORD) >> SEL_W);

    // Write decode
    always_comb begin
        clr_vec = '0;
        if (reg_wr && word == WORD_W'(CLR_WORD)) begin
            clr_vec = reg_wdata[EVT_W-1:0];
        end
        for (int i = 0; i < NUM_IRQ; i++) begin
            mask_we[i] = reg_wr && (word == WORD_W'(MASK_WORD + i));
        end
    end

    card_stat_evt #(
        .EVT_W    (EVT_W),
        .RSVD_IDX (RSVD_IDX)
    ) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (clr_vec),
        .evt_o (evt_q)
    );

    card_stat_mask #(
        .STAT_W  (STAT_W),
        .NUM_IRQ (NUM_IRQ)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (mask_we),
        .wdata_i  (reg_wdata[STAT_W-1:0]),
        .status_i (status),
        .mask_o   (mask_v),
        .irq_o    (irq)
    );

    card_stat_id #(
        .SEL_W (SEL_W)
    ) u_id (
        .sel_i (word[SEL_W-1:0]),
        .id_o  (id_val)
    );

    // Read path: registered, held between reads
    always_comb begin
        rd_d = rd_q;
        if (reg_rd) begin
            rd_d.rdata = '0;
            if (word == WORD_W'(STAT_WORD)) begin
                rd_d.rdata = DATA_W'(status);
            end
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (word == WORD_W'(MASK_WORD + i)) begin
                    rd_d.rdata = DATA_W'(mask_v[i]);
                end
            end
            if (id_hit) begin
                rd_d.rdata = DATA_W'(id_val);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign reg_rdata = rd_q.rdata;

endmodule

// File: rtl/card_stat_chk.sv
module card_stat_chk #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int EVT_W    = 11,
    parameter int LIVE_W   = 11,
    parameter int NUM_IRQ  = 2,
    parameter int RSVD_IDX = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic [EVT_W-1:0]    evt_set,
    input logic [LIVE_W-1:0]   live_lvl,
    input logic [NUM_IRQ-1:0]  irq,
    input logic [EVT_W-1:0]    evt_q
);
    localparam logic [EVT_W-1:0] VALID = ~(EVT_W'(1) << RSVD_IDX);

    logic             clr_hit;
    logic [EVT_W-1:0] set_v;
    assign clr_hit = reg_wr && (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(card_stat_pkg::CLR_WORD));
    assign set_v   = evt_set & VALID;

    // R2 R6
    evt_set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((evt_q & $past(set_v)) == $past(set_v)));

    // R5
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((evt_q & $past(reg_wdata[EVT_W-1:0] & ~set_v)) == '0));

    // R2
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && evt_set == '0) |=> $stable(evt_q));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q[RSVD_IDX] == 1'b0);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && evt_set == '0) |=> (irq == $past(irq) || live_lvl != $past(live_lvl)));

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

bind card_stat_irq card_stat_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .EVT_W    (EVT_W),
    .LIVE_W   (LIVE_W),
    .NUM_IRQ  (NUM_IRQ),
    .RSVD_IDX (RSVD_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_set   (evt_set),
    .live_lvl  (live_lvl),
    .irq       (irq),
    .evt_q     (evt_q)
);

// File: tb/card_stat_irq_test.sv
`timescale 1ns/1ps
module card_stat_irq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] evt_set = '0;
    logic [10:0] live_lvl = '0;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [10:0] m_evt = '0;
    logic [21:0] m_mask0 = '0;
    logic [21:0] m_mask1 = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    card_stat_irq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_set   (evt_set),
        .live_lvl  (live_lvl),
        .irq       (irq)
    );

    function automatic logic [31:0] stat_exp();
        return {10'b0, live_lvl, m_evt};
    endfunction

    function automatic logic [1:0] irq_exp();
        logic [21:0] s;
        s = {live_lvl, m_evt};
        return {|(s & m_mask1), |(s & m_mask0)};
    endfunction

    function automatic logic [7:0] id_exp(input int k);
        case (k)
            0: return 8'h81;
            1: return 8'h11;
            2: return 8'h04;
            3: return 8'h00;
            4: return 8'h0D;
            5: return 8'hF0;
            6: return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    // Monitor: one read result due per captured strobe
    always @(posedge clk) rd_seen <= reg_rd;

    always @(negedge clk) begin
        if (rd_seen && !done) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read result actual=%h expected=none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [10:0] b);
        evt_set = b;
        @(negedge clk);
        evt_set = '0;
        m_evt = m_evt | (b & ~11'h200);
    endtask

    task automatic chk_irq(input string t);
        n_chk++;
        if (irq !== irq_exp()) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", t, irq, irq_exp());
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (irq !== 2'b00 || reg_rdata !== 32'h0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual=%b/%h expected=00/00000000", irq, reg_rdata);
        end
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h034, 32'h0, "R1 status after reset");
        rd(12'h03C, 32'h0, "R1 mask0 after reset");
        rd(12'h040, 32'h0, "R1 mask1 after reset");
        chk_irq("R1 irq after reset");

        // R2 R3: every event pulse, reserved ignored
        pulse(11'h7FF);
        rd(12'h034, stat_exp(), "R2 R3 all events set");
        pulse(11'h000);
        rd(12'h034, stat_exp(), "R2 events sticky");

        // R5: clear selected bits
        wr(12'h038, 32'h0000_00F3);
        m_evt = m_evt & ~11'h0F3;
        rd(12'h034, stat_exp(), "R5 partial clear");
        // R4 live bits; R5 upper clear bits ignored
        live_lvl = 11'h5A5;
        wr(12'h038, 32'hFFFF_F800);
        rd(12'h034, stat_exp(), "R4 R5 live bits and high clear");
        rd(12'h035, stat_exp(), "R10 low address bits ignored");

        // R6: set and clear together
        wr(12'h038, 32'h7FF);
        m_evt = '0;
        evt_set = 11'h001; reg_wr = 1'b1; reg_addr = 12'h038; reg_wdata = 32'h0000_0001;
        @(negedge clk);
        evt_set = '0; reg_wr = 1'b0;
        m_evt = 11'h001;
        rd(12'h034, stat_exp(), "R6 set wins over clear");

        // R7: masks
        wr(12'h03C, 32'hFFFF_FFFF);
        m_mask0 = 22'h3FFFFF;
        rd(12'h03C, 32'h003F_FFFF, "R7 mask0 width");
        wr(12'h040, 32'h0000_0100);
        m_mask1 = 22'h000100;
        rd(12'h040, 32'h0000_0100, "R7 mask1 readback");
        chk_irq("R8 mask0 with live bits");

        // R8: interrupt decode
        live_lvl = '0;
        wr(12'h038, 32'h7FF);
        m_evt = '0;
        wr(12'h03C, 32'h0000_0008);
        m_mask0 = 22'h8;
        wr(12'h040, 32'h0000_1000);
        m_mask1 = 22'h1000;
        chk_irq("R8 both low");
        pulse(11'h008);
        chk_irq("R8 irq0 from event");
        live_lvl = 11'h002;
        @(negedge clk);
        chk_irq("R8 irq1 from live bit");
        wr(12'h038, 32'h008);
        m_evt = '0;
        chk_irq("R8 irq0 after clear");
        live_lvl = '0;
        @(negedge clk);
        chk_irq("R8 irq1 after live drop");

        // R9: identification window
        for (int k = 0; k < 8; k++) begin
            rd(12'hFE0 + 12'(k * 4), {24'h0, id_exp(k)}, "R9 id byte");
        end

        // R10: unmapped and read-only
        pulse(11'h100);
        rd(12'h044, 32'h0, "R10 unmapped read");
        rd(12'h038, 32'h0, "R10 clear offset reads zero");
        rd(12'h000, 32'h0, "R10 offset zero reads zero");
        wr(12'h034, 32'hFFFF_FFFF);
        wr(12'h044, 32'hFFFF_FFFF);
        wr(12'hFE0, 32'hFFFF_FFFF);
        rd(12'h034, stat_exp(), "R10 status unchanged by writes");
        rd(12'h03C, 32'h8, "R10 mask0 unchanged");
        rd(12'hFE0, 32'h81, "R10 id unchanged");

        repeat (3) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R4 pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule